// File: doc/BRIEF.md
# Frequency-Trimmed Precision Time Counter

This block holds the 64-bit time count of a precision time protocol clock. Each cycle it adds a programmable addend into a 32-bit fractional accumulator. Whenever that addition carries out of the top bit, the time count advances by one tick, and each tick stands for 32 ns. Software trims the clock rate by rewriting the addend. The reset addend of 0xA0000000 gives one tick every 1.6 cycles on average, and a correction of plus or minus addend × ppb / 1e9 shifts the rate by that many parts per billion.

Software uses a simple 32-bit register port. The 64-bit time is split into a low word and a high word, and both reads and writes go low word first. A low-word read freezes the matching high word, so that the next high-word read is coherent. A low-word write is buffered until the high-word write, which loads all 64 bits at once. A 64-bit target register raises a sticky pending flag once the time reaches it. A control bit holds the counter in reset. By default the low word wraps at a reduced limit. An unlock sequence reprograms that limit, and writing 0xFFFFFFFF through it restores the full 32-bit range of the low word.

Top module: `ptp_time_core`

## Requirements
- R1: After rst, time_o is 0, tgt_pend_o is 0, the addend reads 0xA0000000, the target reads 0xFFFFFFFF in both words, the wrap limit reads WRAP_RST (default 0x7FFFFFFF) and the unlock bit reads 0.
- R2: In each cycle where accumulator plus addend carries out of bit 31, time_o rises by exactly one at the next edge; otherwise it holds. The accumulator keeps the 32-bit sum.
- R3: A write to offset 2 loads the addend, which sets the tick rate. Addend 0 stops the count, 0x80000000 gives one tick per two cycles, and the reset addend gives 10 ticks in 16 cycles from a cleared accumulator.
- R4: A write to offset 3 (time low) only fills a buffer and leaves time_o unchanged. A write to offset 4 (time high) loads {wdata, buffer} into time_o at the next edge.
- R5: reg_rdata is registered and is valid in the cycle after reg_rd. A read of offset 3 returns the low word and latches the high word into a shadow. A read of offset 4 returns that shadow, even if the time has since carried into the high word.
- R6: Control offset 0, bit 0, is a soft reset. It reads back, and from the edge after it is set until it is cleared, time_o and the accumulator are held at 0 and the pending flag at 0. The addend and target keep their values.
- R7: Target low (offset 5) is buffered and committed together with target high (offset 6). The pending flag, event offset 1 bit 1, is set one cycle after time_o >= target. It stays set until a write of 1 to event bit 1, and a set condition in the same cycle wins over the clear.
- R8: When a tick finds the low word equal to the wrap limit, the low word goes to 0 and the high word rises by one. A low word above the limit counts on to 0xFFFFFFFF and rolls over normally.
- R9: Writes to the limit value (offset 8) take effect only while unlock offset 7, bit 0, is 1; otherwise they are ignored. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator steps on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after reg_rd |
| time_o | output | 2*DATA_W | Current time count, in 32 ns units |
| tgt_pend_o | output | 1 | Target-time pending flag |

## Verification
The bench drives a time value just below a 32-bit rollover. It then reads the low word and reads the high word only after the carry has landed. A design without the shadow would return the new high word and produce a torn 64-bit value. It also loads a time whose low word equals the programmed limit, and one whose low word sits above it. A wrong wrap compare would either miss the wrap and count straight past the limit, or wrap early at the wrong point. Further cases check three things: that a limit write without the unlock bit leaves the limit unchanged; that clearing the pending flag while the time is still at or past the target leaves it set, which would fail if the clear took priority; and that a lone low-word time write leaves the count unchanged, which a design committing word by word would break.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  // register word offsets
  localparam int OFS_CTRL    = 0;
  localparam int OFS_EVENT   = 1;
  localparam int OFS_ADDEND  = 2;
  localparam int OFS_TIME_LO = 3;
  localparam int OFS_TIME_HI = 4;
  localparam int OFS_TGT_LO  = 5;
  localparam int OFS_TGT_HI  = 6;
  localparam int OFS_LIM_EN  = 7;
  localparam int OFS_LIM_VAL = 8;
  // bit positions inside control and event words
  localparam int CTRL_SRST_BIT = 0;
  localparam int EVT_PEND_BIT  = 1;
endpackage

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc #(
  parameter int                ACC_W      = 32,
  parameter logic [ACC_W-1:0]  ADDEND_RST = 32'hA000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic [ACC_W-1:0] addend_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, addend_o};
  assign carry_o = sum[ACC_W] & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      addend_o <= ADDEND_RST;
    end else begin
      acc_q <= clr ? '0 : sum[ACC_W-1:0];
      if (addend_we) addend_o <= addend_wdata;
    end
  end
endmodule

// File: rtl/ptp_time_reg.sv
module ptp_time_reg #(
  parameter int               HALF_W   = 32,
  parameter logic [HALF_W-1:0] WRAP_RST = 32'h7FFF_FFFF,
  localparam int              TIME_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              lim_en_we,
  input  logic              lim_val_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [TIME_W-1:0] time_o,
  output logic              lim_en_o,
  output logic [HALF_W-1:0] lim_o
);
  logic [HALF_W-1:0] lo_buf_q;
  logic [HALF_W-1:0] lo_w, hi_w;
  logic              at_limit;

  assign lo_w     = time_o[HALF_W-1:0];
  assign hi_w     = time_o[TIME_W-1:HALF_W];
  assign at_limit = (lo_w == lim_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_o   <= '0;
      lo_buf_q <= '0;
      lim_en_o <= 1'b0;
      lim_o    <= WRAP_RST;
    end else begin
      if (lo_we)     lo_buf_q <= wdata;
      if (lim_en_we) lim_en_o <= wdata[0];
      if (lim_val_we && lim_en_o) lim_o <= wdata;
      if (clr)
        time_o <= '0;
      else if (hi_we)
        time_o <= {wdata, lo_buf_q};
      else if (tick) begin
        if (at_limit) time_o <= {hi_w + 1'b1, {HALF_W{1'b0}}};
        else          time_o <= time_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptp_tgt_cmp.sv
module ptp_tgt_cmp #(
  parameter int  HALF_W = 32,
  localparam int TIME_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] wdata,
  input  logic [TIME_W-1:0] time_i,
  input  logic              pend_clr,
  output logic [TIME_W-1:0] target_o,
  output logic              pend_o
);
  logic [HALF_W-1:0] lo_buf_q;
  logic              reached;

  assign reached = (time_i >= target_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_buf_q <= '0;
      target_o <= '1;
      pend_o   <= 1'b0;
    end else begin
      if (lo_we) lo_buf_q <= wdata;
      if (hi_we) target_o <= {wdata, lo_buf_q};
      if (clr) pend_o <= 1'b0;
      else     pend_o <= reached | (pend_o & ~pend_clr);
    end
  end
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
  parameter int                 DATA_W     = 32,
  parameter int                 ADDR_W     = 4,
  parameter logic [DATA_W-1:0]  ADDEND_RST = 32'hA000_0000,
  parameter logic [DATA_W-1:0]  WRAP_RST   = 32'h7FFF_FFFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [2*DATA_W-1:0]   time_o,
  output logic                  tgt_pend_o
);
  import ptp_tc_pkg::*;
  localparam int TIME_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] AD_EVENT   = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] AD_ADDEND  = ADDR_W'(OFS_ADDEND);
  localparam logic [ADDR_W-1:0] AD_TIME_LO = ADDR_W'(OFS_TIME_LO);
  localparam logic [ADDR_W-1:0] AD_TIME_HI = ADDR_W'(OFS_TIME_HI);
  localparam logic [ADDR_W-1:0] AD_TGT_LO  = ADDR_W'(OFS_TGT_LO);
  localparam logic [ADDR_W-1:0] AD_TGT_HI  = ADDR_W'(OFS_TGT_HI);
  localparam logic [ADDR_W-1:0] AD_LIM_EN  = ADDR_W'(OFS_LIM_EN);
  localparam logic [ADDR_W-1:0] AD_LIM_VAL = ADDR_W'(OFS_LIM_VAL);

  logic              srst_q;
  logic              carry;
  logic [DATA_W-1:0] addend;
  logic [TIME_W-1:0] target;
  logic              lim_en;
  logic [DATA_W-1:0] lim_val;
  logic [DATA_W-1:0] shadow_q;

  logic we_ctrl, we_event, we_addend, we_tlo, we_thi, we_glo, we_ghi, we_len, we_lval;
  assign we_ctrl   = reg_wr && (reg_addr == AD_CTRL);
  assign we_event  = reg_wr && (reg_addr == AD_EVENT);
  assign we_addend = reg_wr && (reg_addr == AD_ADDEND);
  assign we_tlo    = reg_wr && (reg_addr == AD_TIME_LO);
  assign we_thi    = reg_wr && (reg_addr == AD_TIME_HI);
  assign we_glo    = reg_wr && (reg_addr == AD_TGT_LO);
  assign we_ghi    = reg_wr && (reg_addr == AD_TGT_HI);
  assign we_len    = reg_wr && (reg_addr == AD_LIM_EN);
  assign we_lval   = reg_wr && (reg_addr == AD_LIM_VAL);

  always_ff @(posedge clk) begin
    if (rst)          srst_q <= 1'b0;
    else if (we_ctrl) srst_q <= reg_wdata[CTRL_SRST_BIT];
  end

  ptp_frac_acc #(.ACC_W(DATA_W), .ADDEND_RST(ADDEND_RST)) u_acc (
    .clk(clk), .rst(rst), .clr(srst_q),
    .addend_we(we_addend), .addend_wdata(reg_wdata),
    .addend_o(addend), .carry_o(carry)
  );

  ptp_time_reg #(.HALF_W(DATA_W), .WRAP_RST(WRAP_RST)) u_time (
    .clk(clk), .rst(rst), .clr(srst_q), .tick(carry),
    .lo_we(we_tlo), .hi_we(we_thi),
    .lim_en_we(we_len), .lim_val_we(we_lval),
    .wdata(reg_wdata), .time_o(time_o),
    .lim_en_o(lim_en), .lim_o(lim_val)
  );

  ptp_tgt_cmp #(.HALF_W(DATA_W)) u_tgt (
    .clk(clk), .rst(rst), .clr(srst_q),
    .lo_we(we_glo), .hi_we(we_ghi), .wdata(reg_wdata),
    .time_i(time_o), .pend_clr(we_event && reg_wdata[EVT_PEND_BIT]),
    .target_o(target), .pend_o(tgt_pend_o)
  );

  // registered read port with coherent high-word shadow
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      shadow_q  <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        AD_CTRL:    reg_rdata <= DATA_W'(srst_q) << CTRL_SRST_BIT;
        AD_EVENT:   reg_rdata <= DATA_W'(tgt_pend_o) << EVT_PEND_BIT;
        AD_ADDEND:  reg_rdata <= addend;
        AD_TIME_LO: begin
          reg_rdata <= time_o[DATA_W-1:0];
          shadow_q  <= time_o[TIME_W-1:DATA_W];
        end
        AD_TIME_HI: reg_rdata <= shadow_q;
        AD_TGT_LO:  reg_rdata <= target[DATA_W-1:0];
        AD_TGT_HI:  reg_rdata <= target[TIME_W-1:DATA_W];
        AD_LIM_EN:  reg_rdata <= DATA_W'(lim_en);
        AD_LIM_VAL: reg_rdata <= lim_val;
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ptp_time_core_chk.sv
module ptp_time_core_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [2*DATA_W-1:0] time_o,
  input logic                tgt_pend_o,
  input logic                srst_q
);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(ptp_tc_pkg::OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_THI = ADDR_W'(ptp_tc_pkg::OFS_TIME_HI);

  // R1: reset clears the count and flag
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (time_o == '0 && !tgt_pend_o));

  // R2 and R8: without a load or soft reset the count holds, steps by one, or wraps into the high word
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!srst_q && !(reg_wr && reg_addr == A_THI)) |=>
      (time_o == $past(time_o)) || (time_o == $past(time_o) + 1'b1) ||
      (time_o[DATA_W-1:0] == '0 &&
       time_o[2*DATA_W-1:DATA_W] == $past(time_o[2*DATA_W-1:DATA_W]) + 1'b1));

  // R4: high-word write commits its data into the high half
  a_r4_hi_commit: assert property (@(posedge clk) disable iff (rst)
    (!srst_q && reg_wr && reg_addr == A_THI) |=>
      time_o[2*DATA_W-1:DATA_W] == $past(reg_wdata));

  // R6: soft reset holds the count and flag at zero
  a_r6_soft_hold: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (time_o == '0 && !tgt_pend_o));

  // R7: pending stays set unless cleared by write-one or soft reset
  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    (tgt_pend_o && !srst_q && !(reg_wr && reg_addr == A_EVT && reg_wdata[1])) |=> tgt_pend_o);
endmodule

bind ptp_time_core ptp_time_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .time_o(time_o), .tgt_pend_o(tgt_pend_o), .srst_q(srst_q)
);

// File: tb/test_ptp_time_core.sv
module test_ptp_time_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_o;
  logic        tgt_pend_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_time_core i_ptp_time_core (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_o(time_o), .tgt_pend_o(tgt_pend_o)
  );

  // behavioural reference state
  logic [63:0] m_time, m_tgt;
  logic [31:0] m_acc, m_add, m_lim, m_lobuf, m_globuf, m_shadow, m_rdata;
  bit          m_pend, m_srst, m_limen;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [32:0] s;
    logic [63:0] nt;
    logic        nc;
    s = {1'b0, m_acc} + {1'b0, m_add};
    if (rst) begin
      m_time = 0; m_tgt = '1; m_acc = 0; m_add = 32'hA000_0000; m_lim = 32'h7FFF_FFFF;
      m_lobuf = 0; m_globuf = 0; m_shadow = 0; m_rdata = 0; m_pend = 0; m_srst = 0; m_limen = 0;
      return;
    end
    if (reg_rd) begin
      case (reg_addr)
        0: m_rdata = {31'd0, m_srst};
        1: m_rdata = {30'd0, m_pend, 1'b0};
        2: m_rdata = m_add;
        3: begin m_rdata = m_time[31:0]; m_shadow = m_time[63:32]; end
        4: m_rdata = m_shadow;
        5: m_rdata = m_tgt[31:0];
        6: m_rdata = m_tgt[63:32];
        7: m_rdata = {31'd0, m_limen};
        8: m_rdata = m_lim;
        default: m_rdata = 0;
      endcase
    end
    nc = m_pend && !(reg_wr && reg_addr == 1 && reg_wdata[1]);
    if (m_srst) nt = 0;
    else if (reg_wr && reg_addr == 4) nt = {reg_wdata, m_lobuf};
    else if (s[32]) nt = (m_time[31:0] == m_lim) ? {m_time[63:32] + 32'd1, 32'd0} : m_time + 64'd1;
    else nt = m_time;
    m_pend = m_srst ? 1'b0 : ((m_time >= m_tgt) || nc);
    m_acc  = m_srst ? 32'd0 : s[31:0];
    m_time = nt;
    if (reg_wr) begin
      case (reg_addr)
        0: m_srst = reg_wdata[0];
        2: m_add = reg_wdata;
        3: m_lobuf = reg_wdata;
        5: m_globuf = reg_wdata;
        6: m_tgt = {reg_wdata, m_globuf};
        7: m_limen = reg_wdata[0];
        8: if (m_limen) m_lim = reg_wdata;
        default: ;
      endcase
    end
  endtask

  // one clock: update the model at the edge, compare just after it
  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    chk("R2 model time", time_o, m_time);
    chk("R7 model pending", {63'd0, tgt_pend_o}, {63'd0, m_pend});
    chk("R5 model rdata", {32'd0, reg_rdata}, {32'd0, m_rdata});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    cyc();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic soft_clear();
    wr_reg(4'd0, 32'd1);
    cyc();
    wr_reg(4'd0, 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    idle(4);
    rst = 1'b0;
    // R1 reset values
    chk("R1 time", time_o, 64'd0);
    chk("R1 pending", {63'd0, tgt_pend_o}, 64'd0);
    rd_reg(4'd2, d); chk("R1 addend", {32'd0, d}, 64'h0000_0000_A000_0000);
    rd_reg(4'd8, d); chk("R1 limit", {32'd0, d}, 64'h7FFF_FFFF);
    rd_reg(4'd6, d); chk("R1 target hi", {32'd0, d}, 64'hFFFF_FFFF);
    rd_reg(4'd7, d); chk("R1 unlock", {32'd0, d}, 64'd0);

    // R2 / R3: default addend rate from a cleared accumulator
    idle(37);
    soft_clear();
    idle(16);
    chk("R2 R3 16 cycles default addend", time_o, 64'd10);
    // R6: soft reset readback and hold
    wr_reg(4'd0, 32'd1);
    rd_reg(4'd0, d); chk("R6 ctrl readback", {32'd0, d}, 64'd1);
    chk("R6 time held", time_o, 64'd0);
    rd_reg(4'd2, d); chk("R6 addend kept", {32'd0, d}, 64'h0000_0000_A000_0000);
    wr_reg(4'd0, 32'd0);
    // R3 half rate
    wr_reg(4'd2, 32'h8000_0000);
    soft_clear();
    idle(16);
    chk("R3 half rate", time_o, 64'd8);
    // R3 addend zero stops the count
    wr_reg(4'd2, 32'd0);
    idle(2);
    t = time_o;
    idle(20);
    chk("R3 zero addend holds", time_o, t);

    // R4: low write alone has no effect, high write commits
    wr_reg(4'd3, 32'h1111_1111);
    idle(3);
    chk("R4 low write ignored", time_o, t);
    wr_reg(4'd4, 32'h2222_2222);
    chk("R4 atomic commit", time_o, 64'h2222_2222_1111_1111);

    // R5: coherent read across a low-word rollover
    wr_reg(4'd3, 32'hFFFF_FFF8);
    wr_reg(4'd4, 32'h0000_0005);
    wr_reg(4'd2, 32'hFFFF_FFFF);
    t = time_o;
    rd_reg(4'd3, d); chk("R5 low word", {32'd0, d}, {32'd0, t[31:0]});
    idle(20);
    chk("R5 time moved into next high", {32'd0, time_o[63:32]}, 64'd6);
    rd_reg(4'd4, d); chk("R5 shadow high", {32'd0, d}, {32'd0, t[63:32]});

    // R7: target compare, stickiness, set-over-clear, clear
    wr_reg(4'd5, time_o[31:0] + 32'd10);
    wr_reg(4'd6, time_o[63:32]);
    chk("R7 not yet pending", {63'd0, tgt_pend_o}, 64'd0);
    idle(15);
    chk("R7 pending raised", {63'd0, tgt_pend_o}, 64'd1);
    wr_reg(4'd1, 32'h2);
    idle(1);
    chk("R7 set wins over clear", {63'd0, tgt_pend_o}, 64'd1);
    wr_reg(4'd5, 32'hFFFF_FFFF);
    wr_reg(4'd6, 32'hFFFF_FFFF);
    idle(2);
    wr_reg(4'd1, 32'h2);
    chk("R7 cleared", {63'd0, tgt_pend_o}, 64'd0);
    rd_reg(4'd1, d); chk("R7 event bit", {32'd0, d}, 64'd0);

    // R9: locked limit write ignored, unmapped reads zero
    wr_reg(4'd8, 32'h100);
    rd_reg(4'd8, d); chk("R9 locked write ignored", {32'd0, d}, 64'h7FFF_FFFF);
    rd_reg(4'd15, d); chk("R9 unmapped zero", {32'd0, d}, 64'd0);

    // R8: wrap at the default limit
    wr_reg(4'd3, 32'h7FFF_FFF0);
    wr_reg(4'd4, 32'h0000_0003);
    idle(30);
    chk("R8 wrap at default limit", {32'd0, time_o[63:32]}, 64'd4);
    chk("R8 low restarted", {63'd0, time_o[31:0] < 32'h20}, 64'd1);
    // R9 / R8: unlock and program a small limit
    wr_reg(4'd7, 32'd1);
    wr_reg(4'd8, 32'h100);
    wr_reg(4'd7, 32'd0);
    rd_reg(4'd8, d); chk("R9 unlocked write taken", {32'd0, d}, 64'h100);
    wr_reg(4'd3, 32'h0000_00F0);
    wr_reg(4'd4, 32'd0);
    idle(30);
    chk("R8 wrap at programmed limit", {32'd0, time_o[63:32]}, 64'd1);
    // R8: low word above the limit rolls over naturally
    wr_reg(4'd3, 32'hFFFF_FFF0);
    wr_reg(4'd4, 32'd7);
    idle(30);
    chk("R8 natural rollover", {32'd0, time_o[63:32]}, 64'd8);
    // R8: full range restored
    wr_reg(4'd7, 32'd1);
    wr_reg(4'd8, 32'hFFFF_FFFF);
    wr_reg(4'd7, 32'd0);
    wr_reg(4'd3, 32'h0000_00F0);
    wr_reg(4'd4, 32'd0);
    idle(30);
    chk("R8 no wrap at old limit", {32'd0, time_o[63:32]}, 64'd0);
    chk("R8 counted past old limit", {63'd0, time_o[31:0] > 32'h100}, 64'd1);

    // R6: soft reset clears a pending flag
    wr_reg(4'd5, 32'd0);
    wr_reg(4'd6, 32'd0);
    idle(2);
    wr_reg(4'd0, 32'd1);
    cyc();
    chk("R6 pending cleared", {63'd0, tgt_pend_o}, 64'd0);
    wr_reg(4'd0, 32'd0);
    idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule